// File: doc/BRIEF.md
# Punctured Soft-Decision Viterbi Decoder

This block recovers the information bits of a rate-1/2, constraint-length-7 convolutional code. The encoder generators are 171 and 133 octal. The input is a stream of 4-bit soft values carried on an I/Q pair. A rate selector picks one of eight puncturing schemes, from 1/2 up to 8/9. The depuncturer sits behind a small elastic buffer. It regroups the incoming soft values into trellis steps and marks each position the transmitter dropped as an erasure.

Each trellis step drives a 64-state add-compare-select array. All path metrics are pulled back together whenever the smallest one reaches half the metric range. Every state keeps a 144-bit survivor path, updated by register exchange. The decoded bit is the oldest bit of the survivor that belongs to the best-metric state.

A lock monitor counts normalisation events over windows of 256 trellis steps. It declares lock when a window stays below a programmable limit. The code rate and the spectral orientation are chosen by logic outside the block. Any change of rate is applied together with a reset.

Top module: `vit_decoder`

States and transitions. The output gate has two states. `DF_FILL` is entered at reset. It moves to `DF_STREAM` on the trellis step that completes the 144th step, and `DF_STREAM` holds until the next reset. The lock monitor also has two states. `LK_SEARCH` is entered at reset. At every window end it moves to `LK_LOCKED` if the window's event count is below the limit. `LK_LOCKED` falls back to `LK_SEARCH` when a window reaches or exceeds the limit.

## Requirements
- R1: After reset, and after any later reset, `dec_valid` and `dec_locked` are both 0.
- R2: Soft values are offset binary: 0 is the most confident 0 and 15 the most confident 1. The encoder shift register is {u_t, u_t-1, ..., u_t-6} with the newest bit as MSB. X is the parity of that register ANDed with 7'o171, and Y the parity of the register ANDed with 7'o133. At `rate_sel`=0, an error-free stream decodes to the original bits, in order.
- R3: The kept coded values form one serial stream. For each step, X comes before Y, and only kept positions appear. `sym_i` carries the even entries of this stream and `sym_q` the odd entries. Puncturing position 0 lines up with the first `sym_i` after reset.
- R4: `rate_sel` s gives period s+1. The keep masks have bit k for step k of the period. X masks for s=0..7: 01,01,05,01,15,29,51,01 (hex). Y masks for s=0..7: 01,03,03,0F,0B,17,2F,FF (hex). Every rate decodes error-free input correctly.
- R5: Soft values of weak but correct-sign confidence (0..6 for a 0, 9..15 for a 1) still decode correctly. An erased position adds zero cost.
- R6: At rate 1/2, a single soft value inverted to the opposite extreme is corrected.
- R7: No bit is output until 144 trellis steps have been processed. The first output is the first information bit. N steps give exactly N-143 outputs.
- R8: Path metrics are normalised by subtracting the minimum once it reaches half the range. Decoding stays correct over long streams whose metrics grow every step.
- R9: Lock is re-evaluated only at the end of each 256-step window. It becomes 1 when that window had fewer normalisation events than `lock_limit`, and 0 otherwise.
- R10: With `lock_limit` = 0, `dec_locked` never becomes 1.
- R11: At rate 1/2, a symbol pair is accepted on every cycle. At the other rates, pairs arrive at most every second cycle and no value is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 3 | Puncturing rate code, 0 = 1/2 through 7 = 8/9 |
| sym_valid | input | 1 | A soft I/Q pair is present |
| sym_i | input | 4 | Soft value, even serial position |
| sym_q | input | 4 | Soft value, odd serial position |
| lock_limit | input | 9 | Normalisation events per window below which lock is declared |
| dec_valid | output | 1 | Decoded bit present |
| dec_bit | output | 1 | Decoded information bit |
| dec_locked | output | 1 | Lock indication |

## Verification
The decoder is driven with random information bits at every rate, encoded by an independent bench encoder. Full-confidence soft values check the code polynomials and the puncture masks, since any wrong mask or tap makes the output differ. Random weak-confidence values test that the soft costs and erasures are weighted correctly. A single inverted value shows real correction rather than pass-through. A long run at constant weak confidence forces many normalisations, and mid-scale values that carry no information drive the lock monitor out of lock.

// File: rtl/vit_pkg.sv
package vit_pkg;
    localparam int SOFT_W  = 4;
    localparam int K       = 7;
    localparam int STATE_W = K - 1;
    localparam int NSTATE  = 1 << STATE_W;
    localparam logic [K-1:0] GEN_X = 7'o171;
    localparam logic [K-1:0] GEN_Y = 7'o133;

    typedef logic [SOFT_W-1:0] soft_t;
    localparam soft_t SOFT_MAX = '1;

    // keep mask of the X branch, bit k = step k of the puncturing period
    function automatic logic [7:0] keep_x(input logic [2:0] r);
        case (r)
            3'd2:    return 8'h05;
            3'd4:    return 8'h15;
            3'd5:    return 8'h29;
            3'd6:    return 8'h51;
            default: return 8'h01;
        endcase
    endfunction

    function automatic logic [7:0] keep_y(input logic [2:0] r);
        case (r)
            3'd0:    return 8'h01;
            3'd1:    return 8'h03;
            3'd2:    return 8'h03;
            3'd3:    return 8'h0F;
            3'd4:    return 8'h0B;
            3'd5:    return 8'h17;
            3'd6:    return 8'h2F;
            default: return 8'hFF;
        endcase
    endfunction

    // distance of a soft value from the hypothesised bit; erasures cost nothing
    function automatic logic [SOFT_W:0] soft_cost(input soft_t v, input logic want, input logic erased);
        if (erased) return '0;
        return want ? {1'b0, SOFT_MAX - v} : {1'b0, v};
    endfunction
endpackage

// File: rtl/vit_depunct.sv
module vit_depunct
    import vit_pkg::*;
#(
    parameter int BUF_N = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  rate_sel,
    input  logic        in_valid,
    input  soft_t       in_i,
    input  soft_t       in_q,
    output logic        step_v,
    output soft_t       step_x,
    output soft_t       step_y,
    output logic        step_ex,
    output logic        step_ey,
    output logic [2:0]  level
);
    soft_t      buf_q [BUF_N];
    soft_t      buf_d [BUF_N];
    logic [2:0] cnt_q, cnt_d, pos_q, need, pop, rem;
    logic [7:0] kx, ky;
    logic       nx, ny, fire;

    always_comb begin
        kx   = keep_x(rate_sel);
        ky   = keep_y(rate_sel);
        nx   = kx[pos_q];
        ny   = ky[pos_q];
        need = {2'b00, nx} + {2'b00, ny};
        fire = cnt_q >= need;
        pop  = fire ? need : 3'd0;
        rem  = cnt_q - pop;
        for (int i = 0; i < BUF_N; i++) begin
            buf_d[i] = (i + int'(pop) < BUF_N) ? buf_q[i + int'(pop)] : '0;
            if (in_valid && i == int'(rem))     buf_d[i] = in_i;
            if (in_valid && i == int'(rem) + 1) buf_d[i] = in_q;
        end
        cnt_d = rem + (in_valid ? 3'd2 : 3'd0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < BUF_N; i++) buf_q[i] <= '0;
            cnt_q   <= '0;
            pos_q   <= '0;
            step_v  <= 1'b0;
            step_x  <= '0;
            step_y  <= '0;
            step_ex <= 1'b1;
            step_ey <= 1'b1;
        end else begin
            buf_q   <= buf_d;
            cnt_q   <= cnt_d;
            step_v  <= fire;
            step_x  <= nx ? buf_q[0] : '0;
            step_y  <= ny ? (nx ? buf_q[1] : buf_q[0]) : '0;
            step_ex <= !nx;
            step_ey <= !ny;
            if (fire) pos_q <= (pos_q == rate_sel) ? 3'd0 : pos_q + 3'd1;
        end
    end

    assign level = cnt_q;
endmodule

// File: rtl/vit_minsel.sv
module vit_minsel
    import vit_pkg::*;
#(
    parameter int PM_W = 10
) (
    input  logic [PM_W-1:0]    pm [NSTATE],
    output logic [PM_W-1:0]    min_pm,
    output logic [STATE_W-1:0] best
);
    always_comb begin
        min_pm = pm[0];
        best   = '0;
        for (int i = 1; i < NSTATE; i++) begin
            if (pm[i] < min_pm) begin
                min_pm = pm[i];
                best   = STATE_W'(i);
            end
        end
    end
endmodule

// File: rtl/vit_acs.sv
module vit_acs
    import vit_pkg::*;
#(
    parameter int PM_W   = 10,
    parameter int TB_LEN = 144
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_v,
    input  soft_t             step_x,
    input  soft_t             step_y,
    input  logic              step_ex,
    input  logic              step_ey,
    input  logic [PM_W-1:0]   min_pm,
    output logic              norm,
    output logic              upd,
    output logic [PM_W-1:0]   pm_q [NSTATE],
    output logic [TB_LEN-1:0] path_q [NSTATE]
);
    localparam logic [PM_W-1:0] HALF = PM_W'(1) << (PM_W - 1);
    localparam logic [PM_W-1:0] INIT = HALF >> 1;

    logic [PM_W-1:0]   pm_d   [NSTATE];
    logic [TB_LEN-1:0] path_d [NSTATE];

    assign norm = step_v && (min_pm >= HALF);

    for (genvar n = 0; n < NSTATE; n++) begin : g_st
        localparam logic [STATE_W-1:0] NS = STATE_W'(n);
        localparam int   P0  = int'({NS[STATE_W-2:0], 1'b0});
        localparam int   P1  = int'({NS[STATE_W-2:0], 1'b1});
        localparam logic BX0 = ^({NS, 1'b0} & GEN_X);
        localparam logic BY0 = ^({NS, 1'b0} & GEN_Y);
        localparam logic BX1 = ^({NS, 1'b1} & GEN_X);
        localparam logic BY1 = ^({NS, 1'b1} & GEN_Y);
        logic [PM_W-1:0] c0, c1;
        logic            pick;
        assign c0   = pm_q[P0] + PM_W'(soft_cost(step_x, BX0, step_ex))
                               + PM_W'(soft_cost(step_y, BY0, step_ey));
        assign c1   = pm_q[P1] + PM_W'(soft_cost(step_x, BX1, step_ex))
                               + PM_W'(soft_cost(step_y, BY1, step_ey));
        assign pick = c1 < c0;
        assign pm_d[n]   = (pick ? c1 : c0) - (norm ? min_pm : '0);
        assign path_d[n] = {pick ? path_q[P1][TB_LEN-2:0] : path_q[P0][TB_LEN-2:0], NS[STATE_W-1]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            upd <= 1'b0;
            for (int n = 0; n < NSTATE; n++) begin
                pm_q[n]   <= (n == 0) ? '0 : INIT;
                path_q[n] <= '0;
            end
        end else begin
            upd <= step_v;
            if (step_v) begin
                for (int n = 0; n < NSTATE; n++) begin
                    pm_q[n]   <= pm_d[n];
                    path_q[n] <= path_d[n];
                end
            end
        end
    end
endmodule

// File: rtl/vit_lockmon.sv
module vit_lockmon #(
    parameter int WIN_W = 8,
    parameter int LIM_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_v,
    input  logic             norm,
    input  logic [LIM_W-1:0] limit,
    output logic             win_end,
    output logic             locked
);
    typedef enum logic {LK_SEARCH, LK_LOCKED} lk_t;
    lk_t              st_q, st_d;
    logic [WIN_W-1:0] win_q;
    logic [LIM_W-1:0] ev_q, ev_sum;

    assign win_end = step_v && (&win_q);
    assign ev_sum  = ev_q + LIM_W'(norm);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LK_SEARCH: if (win_end && ev_sum < limit)   st_d = LK_LOCKED;
            LK_LOCKED: if (win_end && !(ev_sum < limit)) st_d = LK_SEARCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= LK_SEARCH;
            win_q <= '0;
            ev_q  <= '0;
        end else begin
            st_q <= st_d;
            if (step_v) begin
                win_q <= win_q + 1'b1;
                ev_q  <= win_end ? '0 : ev_sum;
            end
        end
    end

    always_comb locked = (st_q == LK_LOCKED);
endmodule

// File: rtl/vit_decoder.sv
module vit_decoder
    import vit_pkg::*;
#(
    parameter int PM_W   = 10,
    parameter int TB_LEN = 144,
    parameter int WIN_W  = 8,
    parameter int LIM_W  = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       rate_sel,
    input  logic             sym_valid,
    input  logic [3:0]       sym_i,
    input  logic [3:0]       sym_q,
    input  logic [LIM_W-1:0] lock_limit,
    output logic             dec_valid,
    output logic             dec_bit,
    output logic             dec_locked
);
    localparam int FC_W = $clog2(TB_LEN);

    typedef enum logic {DF_FILL, DF_STREAM} df_t;
    df_t df_q, df_d;

    logic               step_v, step_ex, step_ey, norm, acs_upd, lk_win_end;
    soft_t              step_x, step_y;
    logic [2:0]         buf_level;
    logic [PM_W-1:0]    min_pm;
    logic [STATE_W-1:0] best;
    logic [PM_W-1:0]    pm_q   [NSTATE];
    logic [TB_LEN-1:0]  path_q [NSTATE];
    logic [FC_W-1:0]    fill_cnt;

    vit_depunct u_dep (
        .clk(clk), .rst(rst), .rate_sel(rate_sel), .in_valid(sym_valid),
        .in_i(sym_i), .in_q(sym_q), .step_v(step_v), .step_x(step_x),
        .step_y(step_y), .step_ex(step_ex), .step_ey(step_ey), .level(buf_level)
    );

    vit_minsel #(.PM_W(PM_W)) u_min (.pm(pm_q), .min_pm(min_pm), .best(best));

    vit_acs #(.PM_W(PM_W), .TB_LEN(TB_LEN)) u_acs (
        .clk(clk), .rst(rst), .step_v(step_v), .step_x(step_x), .step_y(step_y),
        .step_ex(step_ex), .step_ey(step_ey), .min_pm(min_pm), .norm(norm),
        .upd(acs_upd), .pm_q(pm_q), .path_q(path_q)
    );

    vit_lockmon #(.WIN_W(WIN_W), .LIM_W(LIM_W)) u_lock (
        .clk(clk), .rst(rst), .step_v(step_v), .norm(norm), .limit(lock_limit),
        .win_end(lk_win_end), .locked(dec_locked)
    );

    always_comb begin
        df_d = df_q;
        unique case (df_q)
            DF_FILL:   if (step_v && fill_cnt == FC_W'(TB_LEN - 1)) df_d = DF_STREAM;
            DF_STREAM: df_d = DF_STREAM;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            df_q     <= DF_FILL;
            fill_cnt <= '0;
        end else begin
            df_q <= df_d;
            if (step_v && df_q == DF_FILL) fill_cnt <= fill_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid <= 1'b0;
            dec_bit   <= 1'b0;
        end else begin
            dec_valid <= acs_upd && (df_q == DF_STREAM);
            dec_bit   <= path_q[best][TB_LEN-1];
        end
    end
endmodule

// File: rtl/vit_decoder_chk.sv
module vit_decoder_chk #(
    parameter int PM_W   = 10,
    parameter int TB_LEN = 144,
    parameter int LIM_W  = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             step_v,
    input logic             step_ex,
    input logic             step_ey,
    input logic             upd,
    input logic             win_end,
    input logic [PM_W-1:0]  min_pm,
    input logic [2:0]       buf_level,
    input logic [LIM_W-1:0] lock_limit,
    input logic             dec_valid,
    input logic             dec_locked
);
    localparam logic [PM_W:0] PM_CAP = (PM_W+1)'(1) << (PM_W - 1);
    localparam logic [PM_W:0] PM_TOP = PM_CAP + (PM_W+1)'(31);

    logic [8:0] upd_seen;
    always_ff @(posedge clk) begin
        if (rst) upd_seen <= '0;
        else if (upd && upd_seen < 9'(TB_LEN)) upd_seen <= upd_seen + 1'b1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> (!dec_valid && !dec_locked)); // R1
    AST_NO_DOUBLE_ERASE: assert property (@(posedge clk) disable iff (rst) step_v |-> !(step_ex && step_ey)); // R4
    AST_FILL_MUTED: assert property (@(posedge clk) disable iff (rst) dec_valid |-> (upd_seen >= 9'(TB_LEN))); // R7
    AST_METRIC_BOUNDED: assert property (@(posedge clk) disable iff (rst) {1'b0, min_pm} < PM_TOP); // R8
    AST_LOCK_AT_WINDOW: assert property (@(posedge clk) disable iff (rst) !$stable(dec_locked) |-> $past(win_end)); // R9
    AST_ZERO_LIMIT: assert property (@(posedge clk) disable iff (rst) (win_end && lock_limit == '0) |=> !dec_locked); // R10
    AST_BUF_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) buf_level <= 3'd4); // R11
endmodule

bind vit_decoder vit_decoder_chk u_chk (
    .clk(clk), .rst(rst), .step_v(step_v), .step_ex(step_ex), .step_ey(step_ey),
    .upd(acs_upd), .win_end(lk_win_end), .min_pm(min_pm), .buf_level(buf_level),
    .lock_limit(lock_limit), .dec_valid(dec_valid), .dec_locked(dec_locked)
);

// File: tb/vit_decoder_tb.sv
module vit_decoder_tb;
    localparam int TBL = 144;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] rate_sel = '0;
    logic       sym_valid = 1'b0;
    logic [3:0] sym_i = '0, sym_q = '0;
    logic [8:0] lock_limit = 9'd1;
    logic       dec_valid, dec_bit, dec_locked;

    vit_decoder u_dut (
        .clk(clk), .rst(rst), .rate_sel(rate_sel), .sym_valid(sym_valid),
        .sym_i(sym_i), .sym_q(sym_q), .lock_limit(lock_limit),
        .dec_valid(dec_valid), .dec_bit(dec_bit), .dec_locked(dec_locked)
    );

    always #4 clk = ~clk;

    int   n_run = 0, n_fail = 0;
    bit   done = 0;
    logic ubits [0:3999];
    logic [3:0] vals [0:8999];
    int   nvals, nsteps, ocnt, obad, obad_idx;
    logic obad_got;
    bit   chk_on = 0;

    always @(negedge clk) begin
        if (!rst && dec_valid) begin
            if (chk_on && ocnt < nsteps && dec_bit !== ubits[ocnt]) begin
                if (obad == 0) begin obad_idx = ocnt; obad_got = dec_bit; end
                obad++;
            end
            ocnt++;
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int got, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic bit [7:0] mask_x(input int r);
        case (r)
            2: return 8'h05; 4: return 8'h15; 5: return 8'h29; 6: return 8'h51;
            default: return 8'h01;
        endcase
    endfunction

    function automatic bit [7:0] mask_y(input int r);
        case (r)
            0: return 8'h01; 1: return 8'h03; 2: return 8'h03; 3: return 8'h0F;
            4: return 8'h0B; 5: return 8'h17; 6: return 8'h2F; default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [3:0] soft_of(input bit c, input int mode);
        case (mode)
            0: return c ? 4'd15 : 4'd0;
            1: return c ? 4'(9 + $urandom % 7) : 4'($urandom % 7);
            2: return c ? 4'd9 : 4'd6;
            default: return 4'd7;
        endcase
    endfunction

    task automatic build(input int r, input int nb, input int mode, input int flip);
        bit [5:0] st;
        bit [7:0] mx, my;
        st = '0; mx = mask_x(r); my = mask_y(r);
        nvals = 0; nsteps = nb;
        for (int t = 0; t < nb; t++) begin
            bit u; bit [6:0] f; int k;
            u = bit'($urandom & 1);
            f = {u, st};
            k = t % (r + 1);
            ubits[t] = u;
            st = f[6:1];
            if (mx[k]) begin vals[nvals] = soft_of(^(f & 7'o171), mode); nvals++; end
            if (my[k]) begin vals[nvals] = soft_of(^(f & 7'o133), mode); nvals++; end
        end
        if (flip >= 0) vals[flip] = 4'd15 - vals[flip];
    endtask

    task automatic drive(input int gap);
        for (int j = 0; j + 1 < nvals; j += 2) begin
            sym_valid = 1'b1; sym_i = vals[j]; sym_q = vals[j+1];
            @(negedge clk);
            sym_valid = 1'b0;
            repeat (gap) @(negedge clk);
        end
        sym_valid = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; sym_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic int len_for(input int r, input int lo);
        int p2;
        p2 = 2 * (r + 1);
        return p2 * ((lo + p2 - 1) / p2);
    endfunction

    task automatic run_case(input int r, input int nb, input int mode, input int gap, input int flip, input string req);
        do_reset();
        rate_sel = 3'(r);
        build(r, nb, mode, flip);
        ocnt = 0; obad = 0; chk_on = 1;
        drive(gap);
        check(ocnt == nb - TBL + 1, req, $sformatf("output count rate %0d", r), ocnt, nb - TBL + 1);
        check(obad == 0, req, $sformatf("first wrong bit at %0d rate %0d", obad_idx, r),
              int'(obad_got), (obad == 0) ? int'(obad_got) : int'(!obad_got));
        chk_on = 0;
    endtask

    initial begin
        void'($urandom(32'd2024));
        do_reset();
        @(negedge clk);
        check(dec_valid == 1'b0, "R1", "dec_valid after reset", int'(dec_valid), 0);
        check(dec_locked == 1'b0, "R1", "dec_locked after reset", int'(dec_locked), 0);

        // R2 R11: rate 1/2, one pair every cycle
        run_case(0, 400, 0, 0, -1, "R2");
        // R3 R4: every punctured rate, error-free, pairs every second cycle
        for (int r = 1; r < 8; r++) run_case(r, len_for(r, 440), 0, 1, -1, (r == 2) ? "R3" : "R4");
        run_case(0, 300, 0, 1, -1, "R11");
        // R5: random weak confidence, one unpunctured and two punctured rates
        run_case(0, 500, 1, 1, -1, "R5");
        run_case(2, len_for(2, 500), 1, 1, -1, "R5");
        run_case(6, len_for(6, 500), 1, 1, -1, "R5");
        // R6: one value inverted to the opposite extreme
        run_case(0, 500, 0, 0, 301, "R6");
        // R7: shortest stream that yields a single output
        run_case(0, TBL, 0, 0, -1, "R7");
        // R8: constant weak confidence makes the minimum grow every step
        run_case(0, 3000, 2, 1, -1, "R8");

        // R9: clean data locks, uninformative data unlocks, clean again relocks
        do_reset();
        rate_sel = 3'd0; lock_limit = 9'd1;
        build(0, 800, 0, -1); drive(0);
        check(dec_locked == 1'b1, "R9", "lock on clean stream", int'(dec_locked), 1);
        build(0, 800, 3, -1); drive(0);
        check(dec_locked == 1'b0, "R9", "lock on mid-scale stream", int'(dec_locked), 0);
        build(0, 800, 0, -1); drive(0);
        check(dec_locked == 1'b1, "R9", "relock on clean stream", int'(dec_locked), 1);
        do_reset();
        @(negedge clk);
        check(dec_locked == 1'b0, "R1", "lock cleared by reset", int'(dec_locked), 0);

        // R10: zero limit never locks even on clean data
        lock_limit = 9'd0;
        build(0, 800, 0, -1); drive(0);
        check(dec_locked == 1'b0, "R10", "lock with zero limit", int'(dec_locked), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: run did not complete, got 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule